// File: doc/BRIEF.md
# Ethernet MAC Statistics Counter Bank

This block keeps the frame and octet statistics of an Ethernet MAC. The transmit and receive paths drive single-cycle event strobes. The transmit path also supplies the byte count of each good frame. Each event adds to a dedicated counter. Software reads the counters over a simple word-addressed register bus.

A read returns the current count and clears it, so software collects deltas. A counter that reaches its maximum stays there and does not wrap.

Five control levels come from the MAC's network-control register:
- a receive enable that gates the receive-side counters;
- a snapshot trigger that moves all live counts into a shadow set in one cycle;
- a select that points reads at the shadow set;
- two test controls, one allowing direct writes and one adding one to every counter.

Top module: `mac_stat_bank`

## Requirements
- R1: A read (`rd_en` high) returns the addressed value on `rd_data` on the clock edge after the request, and a live-counter read clears that counter. Address map: 0 = octets-sent low 32 bits, 1 = octets-sent high 16 bits, 2 = frames sent, 3 = broadcasts sent, 4 = multicasts sent, 5 = pause frames sent, 6 = frames received, 7 = broadcasts received, 8 = multicasts received. Any other address reads zero. All counters are zero after reset.
- R2: Every counter saturates at all ones and never wraps. This holds for the frame counters (`CNT_W` bits) and for the 48-bit octet counter.
- R3: The receive counters (addresses 6 to 8) count events only while `ctrl_rx_en` is 1. The transmit counters do not depend on it.
- R4: A 0-to-1 change of `ctrl_snap` copies every live counter into the snapshot set. In the same cycle it clears every live counter, keeping only the events of that cycle.
- R5: While `ctrl_snap_sel` is 1, reads return snapshot values. These reads clear neither the snapshot nor the live counters, and events keep adding to the live counters.
- R6: A bus write (`wr_en`) loads the addressed counter only while `ctrl_wr_en` is 1. Otherwise the write has no effect. A write to address 0 or 1 replaces only that part of the octet counter.
- R7: A 0-to-1 change of `ctrl_inc_all` adds exactly one to every counter, including the receive counters whatever `ctrl_rx_en` is. Holding the level high adds nothing further.
- R8: The octet counter is 48 bits wide. It adds `tx_bytes` on each `tx_frame_ok`, with carry from the low word into the high word. A live read of address 0 also stores the high 16 bits. A later live read of address 1 returns that stored value.
- R9: When an event and a clearing read of the same counter fall in the same cycle, the read returns the old value. The counter then holds the amount of that event instead of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_rx_en | input | 1 | Receive enable level |
| ctrl_snap | input | 1 | Snapshot trigger (acts on its rising edge) |
| ctrl_snap_sel | input | 1 | 1 = reads come from the snapshot set |
| ctrl_wr_en | input | 1 | Test: allow direct counter writes |
| ctrl_inc_all | input | 1 | Test: add one to all counters (acts on its rising edge) |
| tx_frame_ok | input | 1 | Good frame sent |
| tx_bytes | input | BYTE_W | Byte count of the sent frame |
| tx_bcast | input | 1 | Broadcast frame sent |
| tx_mcast | input | 1 | Multicast frame sent |
| tx_pause | input | 1 | Pause frame sent |
| rx_frame_ok | input | 1 | Good frame received |
| rx_bcast | input | 1 | Broadcast frame received |
| rx_mcast | input | 1 | Multicast frame received |
| rd_en | input | 1 | Register read request |
| wr_en | input | 1 | Register write request |
| addr | input | ADDR_W | Register word address |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data, registered |

## Verification
An event strobe, a write, a snapshot edge or an increment-all edge changes the counters at the first rising clock edge that sees it. A read result appears on `rd_data` at the edge that takes the request. The bench drives every stimulus just after a falling edge and removes it after one rising edge. It takes each read value at the following falling edge, one full cycle after the request. Expected counts come from the bench's own sums over event sweeps, clipped at the all-ones value. In the same-cycle cases, the event and the read share one stimulus cycle, and the result is taken from the read that follows.

// File: rtl/mac_stat_pkg.sv
// Package: shared constants of the statistics bank.
// Assumes the frame counters sit at consecutive word addresses after the
// two octet words, with the receive counters last.
package mac_stat_pkg;
    localparam int NUM_FC      = 7;   // frame counters
    localparam int FC_RX_FIRST = 4;   // index of first receive counter
    localparam int ADDR_W      = 4;
    localparam logic [ADDR_W-1:0] A_OCT_LO  = 4'd0;
    localparam logic [ADDR_W-1:0] A_OCT_HI  = 4'd1;
    localparam logic [ADDR_W-1:0] A_FC_BASE = 4'd2;

    // Word address of frame counter i.
    function automatic logic [ADDR_W-1:0] fc_addr(input int i);
        return A_FC_BASE + ADDR_W'(i);
    endfunction
endpackage

// File: rtl/stat_rise_pulse.sv
// Module: turns a control level into a single-cycle pulse on its 0-to-1 change.
// Assumes the level is synchronous to clk. A level already high when reset
// is released produces one pulse.
module stat_rise_pulse (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic pulse
);
    logic prev_q;

    // Remember the level of the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl;
    end

    assign pulse = lvl && !prev_q;

    assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);
endmodule

// File: rtl/stat_sat_counter.sv
// Module: one saturating statistics counter with clear and test load.
// Assumes INC_W <= W. The clear takes effect before the increment, so an
// event in the clearing cycle survives. A load overrides both.
module stat_sat_counter #(
    parameter int W     = 32,
    parameter int INC_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [INC_W-1:0] inc,
    input  logic             ld,
    input  logic [W-1:0]     ld_val,
    output logic [W-1:0]     count
);
    logic [W-1:0] base;
    logic [W:0]   sum;
    logic [W-1:0] nxt;

    // Add the increment to the (possibly cleared) value, clipping at all ones.
    always_comb begin
        base = clr ? '0 : count;
        sum  = {1'b0, base} + (W+1)'(inc);
        nxt  = sum[W] ? '1 : sum[W-1:0];
    end

    // Hold the count.
    always_ff @(posedge clk) begin
        if (!rst_n)  count <= '0;
        else if (ld) count <= ld_val;
        else         count <= nxt;
    end

    assert_clear_on_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !ld && inc == '0) |=> (count == '0));
    assert_no_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !ld) |=> (count >= $past(count)));
    assert_saturate_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !ld && (&count)) |=> (&count));
    assert_keep_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !ld && inc != '0) |=> (count != '0));
endmodule

// File: rtl/stat_read_mux.sv
// Module: selects the read value for an address from the live or snapshot set.
// Assumes CNT_W <= DATA_W and OCT_W > DATA_W. Unmapped addresses give zero.
module stat_read_mux
    import mac_stat_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int DATA_W = 32,
    parameter int OCT_W  = 48,
    localparam int HI_W  = OCT_W - DATA_W
) (
    input  logic [ADDR_W-1:0]             addr,
    input  logic                          use_snap,
    input  logic [OCT_W-1:0]              oct_live,
    input  logic [OCT_W-1:0]              oct_snap,
    input  logic [HI_W-1:0]               oct_hold,
    input  logic [NUM_FC-1:0][CNT_W-1:0]  fc_live,
    input  logic [NUM_FC-1:0][CNT_W-1:0]  fc_snap,
    output logic [DATA_W-1:0]             rd_val
);
    // Decode the address into a data word.
    always_comb begin
        rd_val = '0;
        if (addr == A_OCT_LO)
            rd_val = use_snap ? oct_snap[DATA_W-1:0] : oct_live[DATA_W-1:0];
        else if (addr == A_OCT_HI)
            rd_val = DATA_W'(use_snap ? oct_snap[OCT_W-1:DATA_W] : oct_hold);
        for (int i = 0; i < NUM_FC; i++) begin
            if (addr == fc_addr(i))
                rd_val = DATA_W'(use_snap ? fc_snap[i] : fc_live[i]);
        end
    end
endmodule

// File: rtl/mac_stat_bank.sv
// Module: bank of clear-on-read, saturating MAC statistics counters with a
// snapshot set and test controls.
// Assumes one event per strobe per cycle and control levels synchronous to
// clk. A test write in a cycle takes priority over events for its counter.
module mac_stat_bank
    import mac_stat_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int DATA_W = 32,
    parameter int OCT_W  = 48,
    parameter int BYTE_W = 16,
    localparam int HI_W  = OCT_W - DATA_W,
    localparam int OINC_W = BYTE_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_rx_en,
    input  logic              ctrl_snap,
    input  logic              ctrl_snap_sel,
    input  logic              ctrl_wr_en,
    input  logic              ctrl_inc_all,
    input  logic              tx_frame_ok,
    input  logic [BYTE_W-1:0] tx_bytes,
    input  logic              tx_bcast,
    input  logic              tx_mcast,
    input  logic              tx_pause,
    input  logic              rx_frame_ok,
    input  logic              rx_bcast,
    input  logic              rx_mcast,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);
    logic                         snap_pulse;
    logic                         inc_pulse;
    logic                         rd_live;
    logic                         wr_ok;
    logic [NUM_FC-1:0]            fc_ev;
    logic [NUM_FC-1:0]            fc_clr;
    logic [NUM_FC-1:0]            fc_ld;
    logic [NUM_FC-1:0][CNT_W-1:0] fc_live;
    logic [NUM_FC-1:0][CNT_W-1:0] fc_snap;
    logic [OCT_W-1:0]             oct_live;
    logic [OCT_W-1:0]             oct_snap;
    logic [OCT_W-1:0]             oct_ld_val;
    logic [OINC_W-1:0]            oct_inc;
    logic                         oct_clr;
    logic                         oct_ld;
    logic [HI_W-1:0]              oct_hold;
    logic [DATA_W-1:0]            rd_val;

    stat_rise_pulse u_snap_edge (.clk(clk), .rst_n(rst_n), .lvl(ctrl_snap),    .pulse(snap_pulse));
    stat_rise_pulse u_inc_edge  (.clk(clk), .rst_n(rst_n), .lvl(ctrl_inc_all), .pulse(inc_pulse));

    assign rd_live = rd_en && !ctrl_snap_sel;
    assign wr_ok   = wr_en && ctrl_wr_en;

    // Gather the per-counter event strobes; receive ones obey the enable.
    always_comb begin
        fc_ev[0] = tx_frame_ok;
        fc_ev[1] = tx_bcast;
        fc_ev[2] = tx_mcast;
        fc_ev[3] = tx_pause;
        fc_ev[4] = rx_frame_ok && ctrl_rx_en;
        fc_ev[5] = rx_bcast    && ctrl_rx_en;
        fc_ev[6] = rx_mcast    && ctrl_rx_en;
    end

    // Octet counter controls: byte add, clear on low-word read, partial load.
    always_comb begin
        oct_inc = (tx_frame_ok ? {1'b0, tx_bytes} : '0) + OINC_W'(inc_pulse);
        oct_clr = snap_pulse || (rd_live && addr == A_OCT_LO);
        oct_ld  = wr_ok && (addr == A_OCT_LO || addr == A_OCT_HI);
        if (addr == A_OCT_LO) oct_ld_val = {oct_live[OCT_W-1:DATA_W], wr_data};
        else                  oct_ld_val = {wr_data[HI_W-1:0], oct_live[DATA_W-1:0]};
    end

    stat_sat_counter #(.W(OCT_W), .INC_W(OINC_W)) u_oct (
        .clk(clk), .rst_n(rst_n), .clr(oct_clr), .inc(oct_inc),
        .ld(oct_ld), .ld_val(oct_ld_val), .count(oct_live)
    );

    genvar gi;
    generate
        for (gi = 0; gi < NUM_FC; gi++) begin : g_fc
            assign fc_clr[gi] = snap_pulse || (rd_live && addr == fc_addr(gi));
            assign fc_ld[gi]  = wr_ok && addr == fc_addr(gi);

            stat_sat_counter #(.W(CNT_W), .INC_W(2)) u_cnt (
                .clk(clk), .rst_n(rst_n), .clr(fc_clr[gi]),
                .inc({1'b0, fc_ev[gi]} + {1'b0, inc_pulse}),
                .ld(fc_ld[gi]), .ld_val(wr_data[CNT_W-1:0]), .count(fc_live[gi])
            );

            // Shadow copy taken on the snapshot pulse.
            always_ff @(posedge clk) begin
                if (!rst_n)          fc_snap[gi] <= '0;
                else if (snap_pulse) fc_snap[gi] <= fc_live[gi];
            end

            assert_snap_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
                snap_pulse |=> (fc_snap[gi] == $past(fc_live[gi])));
            assert_snap_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
                !snap_pulse |=> $stable(fc_snap[gi]));
            if (gi >= FC_RX_FIRST) begin : g_rx_chk
                assert_rx_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
                    (!ctrl_rx_en && !inc_pulse && !fc_ld[gi]) |=> (fc_live[gi] <= $past(fc_live[gi])));
            end
        end
    endgenerate

    // Shadow copy of the octet counter.
    always_ff @(posedge clk) begin
        if (!rst_n)          oct_snap <= '0;
        else if (snap_pulse) oct_snap <= oct_live;
    end

    // High octet word held at a live low-word read for a consistent pair.
    always_ff @(posedge clk) begin
        if (!rst_n)                           oct_hold <= '0;
        else if (rd_live && addr == A_OCT_LO) oct_hold <= oct_live[OCT_W-1:DATA_W];
    end

    stat_read_mux #(.CNT_W(CNT_W), .DATA_W(DATA_W), .OCT_W(OCT_W)) u_mux (
        .addr(addr), .use_snap(ctrl_snap_sel), .oct_live(oct_live), .oct_snap(oct_snap),
        .oct_hold(oct_hold), .fc_live(fc_live), .fc_snap(fc_snap), .rd_val(rd_val)
    );

    // Register the read data when a read is requested.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= rd_val;
    end

    assert_oct_snap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        snap_pulse |=> (oct_snap == $past(oct_live)));
    assert_write_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_wr_en |-> (fc_ld == '0 && !oct_ld));
    assert_snap_read_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && ctrl_snap_sel && !snap_pulse && !wr_ok) |=> (oct_live >= $past(oct_live)));
endmodule

// File: tb/mac_stat_bank_tb_top.sv
module mac_stat_bank_tb_top;
    localparam int CW = 8;
    localparam int MAXC = (1 << CW) - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_rx_en = 1'b0, ctrl_snap = 1'b0, ctrl_snap_sel = 1'b0;
    logic        ctrl_wr_en = 1'b0, ctrl_inc_all = 1'b0;
    logic        tx_frame_ok = 1'b0, tx_bcast = 1'b0, tx_mcast = 1'b0, tx_pause = 1'b0;
    logic        rx_frame_ok = 1'b0, rx_bcast = 1'b0, rx_mcast = 1'b0;
    logic [15:0] tx_bytes = '0;
    logic        rd_en = 1'b0, wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;

    int total = 0;
    int bad = 0;
    logic [31:0] v;

    always #5 clk = ~clk;

    mac_stat_bank #(.CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .ctrl_rx_en(ctrl_rx_en), .ctrl_snap(ctrl_snap),
        .ctrl_snap_sel(ctrl_snap_sel), .ctrl_wr_en(ctrl_wr_en), .ctrl_inc_all(ctrl_inc_all),
        .tx_frame_ok(tx_frame_ok), .tx_bytes(tx_bytes), .tx_bcast(tx_bcast),
        .tx_mcast(tx_mcast), .tx_pause(tx_pause), .rx_frame_ok(rx_frame_ok),
        .rx_bcast(rx_bcast), .rx_mcast(rx_mcast), .rd_en(rd_en), .wr_en(wr_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] val);
        @(negedge clk); rd_en = 1'b1; addr = a;
        @(negedge clk); rd_en = 1'b0; val = rd_data;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    // m bits: 0 tx frame, 1 tx bcast, 2 tx mcast, 3 tx pause, 4 rx frame, 5 rx bcast, 6 rx mcast
    task automatic ev(input logic [6:0] m, input logic [15:0] b);
        @(negedge clk);
        {rx_mcast, rx_bcast, rx_frame_ok, tx_pause, tx_mcast, tx_bcast, tx_frame_ok} = m;
        tx_bytes = b;
        @(posedge clk); #1;
        {rx_mcast, rx_bcast, rx_frame_ok, tx_pause, tx_mcast, tx_bcast, tx_frame_ok} = '0;
        tx_bytes = '0;
    endtask

    task automatic clear_all();
        for (int a = 0; a < 9; a++) rd(4'(a), v);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] e [9];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state and unmapped address
        for (int a = 0; a < 9; a++) begin rd(4'(a), v); chk("R1 reset", v, 0); end
        rd(4'd15, v); chk("R1 unmapped", v, 0);

        // R1/R8: mixed event sweep with rx enabled
        ctrl_rx_en = 1'b1;
        for (int a = 0; a < 9; a++) e[a] = 0;
        for (int k = 0; k < 40; k++) begin
            logic [6:0] m;
            m = {k % 6 == 0, k % 7 == 0, k % 4 != 0, k % 5 == 0, k % 3 == 0, k % 2 == 0, 1'b1};
            e[0] += 32'(64 + 3 * k);
            for (int j = 0; j < 7; j++) if (m[j]) e[j+2]++;
            ev(m, 16'(64 + 3 * k));
        end
        for (int a = 0; a < 9; a++) begin rd(4'(a), v); chk("R1 sweep count", v, e[a]); end
        for (int a = 2; a < 9; a++) begin rd(4'(a), v); chk("R1 cleared after read", v, 0); end

        // R3: rx disabled, rx events ignored, tx still counted
        ctrl_rx_en = 1'b0;
        for (int k = 0; k < 10; k++) ev(7'b1110001, 16'd10);
        rd(4'd6, v); chk("R3 rx frames gated", v, 0);
        rd(4'd7, v); chk("R3 rx bcast gated", v, 0);
        rd(4'd8, v); chk("R3 rx mcast gated", v, 0);
        rd(4'd2, v); chk("R3 tx frames counted", v, 10);
        clear_all();

        // R2: saturation sweep on frame counters
        foreach (e[i]) e[i] = 0;
        for (int n = 0; n < 4; n++) begin
            int cnt;
            cnt = (n == 0) ? 254 : (n == 1) ? 255 : (n == 2) ? 256 : 300;
            for (int k = 0; k < cnt; k++) ev(7'b0000011, 16'd1);
            rd(4'd2, v); chk("R2 frames saturate", v, (cnt > MAXC) ? MAXC : cnt);
            rd(4'd3, v); chk("R2 bcast saturate", v, (cnt > MAXC) ? MAXC : cnt);
            rd(4'd0, v); chk("R2 octets", v, cnt);
        end

        // R6: write ignored without write enable
        wr(4'd2, 32'd77);
        rd(4'd2, v); chk("R6 write ignored", v, 0);
        wr(4'd0, 32'd5);
        rd(4'd0, v); chk("R6 octet write ignored", v, 0);
        ctrl_wr_en = 1'b1;
        wr(4'd2, 32'd77);
        wr(4'd7, 32'd200);
        ctrl_wr_en = 1'b0;
        rd(4'd2, v); chk("R6 write accepted", v, 77);
        rd(4'd7, v); chk("R6 rx write accepted", v, 200);

        // R8: carry from the low word into the high word
        ctrl_wr_en = 1'b1;
        wr(4'd0, 32'hFFFF_FFF0);
        wr(4'd1, 32'd0);
        ctrl_wr_en = 1'b0;
        ev(7'b0000001, 16'h20);
        rd(4'd0, v); chk("R8 low word", v, 32'h10);
        rd(4'd1, v); chk("R8 held high word", v, 1);
        rd(4'd0, v); chk("R8 cleared low", v, 0);
        rd(4'd1, v); chk("R8 cleared high", v, 0);

        // R2: octet saturation at 48 bits
        ctrl_wr_en = 1'b1;
        wr(4'd0, 32'hFFFF_FFFF);
        wr(4'd1, 32'hFFFF);
        ctrl_wr_en = 1'b0;
        ev(7'b0000001, 16'd100);
        rd(4'd0, v); chk("R2 octet low saturate", v, 32'hFFFF_FFFF);
        rd(4'd1, v); chk("R2 octet high saturate", v, 32'hFFFF);
        clear_all();

        // R7: increment-all, held high, rx disabled
        @(negedge clk); ctrl_inc_all = 1'b1;
        repeat (5) @(negedge clk);
        ctrl_inc_all = 1'b0;
        for (int a = 0; a < 9; a++) begin rd(4'(a), v); chk("R7 inc all once", v, (a == 1) ? 0 : 1); end

        // R4/R5: snapshot copy, clear, and non-clearing snapshot reads
        for (int k = 0; k < 3; k++) ev(7'b0000001, 16'd100);
        @(negedge clk); ctrl_snap = 1'b1;
        repeat (3) @(negedge clk);
        ctrl_snap = 1'b0;
        for (int k = 0; k < 2; k++) ev(7'b0000001, 16'd10);
        ctrl_snap_sel = 1'b1;
        rd(4'd2, v); chk("R4 snapshot frames", v, 3);
        rd(4'd2, v); chk("R5 snapshot not cleared", v, 3);
        rd(4'd0, v); chk("R4 snapshot octets", v, 300);
        rd(4'd1, v); chk("R5 snapshot high", v, 0);
        ctrl_snap_sel = 1'b0;
        rd(4'd2, v); chk("R4 live after snapshot", v, 2);
        rd(4'd0, v); chk("R5 live octets kept", v, 20);

        // R9: event in same cycle as clearing read
        for (int k = 0; k < 5; k++) ev(7'b0000001, 16'd8);
        @(negedge clk);
        rd_en = 1'b1; addr = 4'd2; tx_frame_ok = 1'b1; tx_bytes = 16'd64;
        @(negedge clk);
        rd_en = 1'b0; tx_frame_ok = 1'b0; tx_bytes = '0;
        chk("R9 read returns old", rd_data, 5);
        rd(4'd2, v); chk("R9 event kept", v, 1);
        @(negedge clk);
        rd_en = 1'b1; addr = 4'd0; tx_frame_ok = 1'b1; tx_bytes = 16'd64;
        @(negedge clk);
        rd_en = 1'b0; tx_frame_ok = 1'b0; tx_bytes = '0;
        chk("R9 octet read old", rd_data, 104);
        rd(4'd0, v); chk("R9 octet event kept", v, 64);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule